// File: doc/BRIEF.md
# Block Cipher Register Front End

This block is the register and handshake front end of a 64-bit block cipher accelerator that runs DES or Triple-DES in ECB or CBC mode. A host reaches it through a simple 32-bit read/write port. The host loads the key words, the initial chaining value, the mode bits and a byte count, then starts a session. Each block is fed in as two data words and drained as two data words. The front end raises a per-block interrupt event or a DMA request at each step, and counts the byte length down block by block.

The cipher rounds live in a separate core. The front end hands that core the key, the chaining value, the input block, and the mode and direction bits through a start/done port. It captures the result when the core signals done. The front end also owns the CBC chaining register and updates it after every block.

Top module: `blkc_regfront`

## Requirements
- R1: After reset the control, status, enable, mask and length registers read 0, and irq_o, dma_in_req_o, dma_out_req_o and core_start_o are low.
- R2: Offset 0x30 reads a constant revision: the major version REV_MAJOR sits in bits 10:8, the minor version REV_MINOR in bits 5:0, and all other bits are 0.
- R3: Key word i (0 to 5) is written at byte offset 0x14 - 4*(i XOR 1) and appears on core_key_o bits [32i+31:32i]. Single DES uses words 0 and 1.
- R4: The control register at 0x20 stores CBC in bit 4, Triple-DES in bit 3 and encrypt in bit 2. Bit 1 reads the input-ready flag and bit 0 reads the output-ready flag. Writes to bits 1:0 have no effect.
- R5: A write to the mask register at 0x34 with bit 7 set, while idle and with a length of at least 8, starts a session. Input-ready then rises and status bit 1 is set. With a length below 8, input-ready stays low.
- R6: Data words are written at 0x28 (low word) and 0x2C (high word). Writing 0x2C while input-ready is high launches the core with {high, low} and drops input-ready. Data writes while input-ready is low are ignored and start nothing.
- R7: When core_done_i arrives, the result is latched into the output words, output-ready rises and status bit 2 is set.
- R8: Reading 0x2C while output-ready is high consumes the block and lowers the length at 0x24 by 8. Input-ready (and status bit 1) returns if 8 or more bytes remain; otherwise the block goes idle.
- R9: Writing the status register at 0x3C clears each event bit (1 = input, 2 = output) written as 0 and keeps each written as 1. irq_o is high while any status bit has its enable bit set in the register at 0x40.
- R10: Mask bits 5 and 6 read back and gate dma_in_req_o with input-ready and dma_out_req_o with output-ready. Mask bit 7 always reads 0.
- R11: The chaining value, read at 0x18 (low) and 0x1C (high), drives core_iv_o. In CBC encrypt it takes each result. In CBC decrypt it takes each input block. In ECB it is unchanged.
- R12: Reading the data registers while output-ready is low returns the last result and has no side effect.
- R13: Writes to the length register while a session is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of rd_en_i |
| irq_o | output | 1 | Interrupt request |
| dma_in_req_o | output | 1 | Input DMA request |
| dma_out_req_o | output | 1 | Output DMA request |
| core_start_o | output | 1 | One-cycle launch pulse to the core |
| core_block_o | output | 64 | Input block |
| core_key_o | output | 192 | Six key words |
| core_iv_o | output | 64 | Chaining value |
| core_cbc_o | output | 1 | CBC mode |
| core_tdes_o | output | 1 | Triple-DES mode |
| core_enc_o | output | 1 | 1 = encrypt |
| core_done_i | input | 1 | Core completion pulse |
| core_result_i | input | 64 | Core output block |

## Verification
The hardest state to reach is a chained multi-block CBC run in which the chaining register has been rewritten by the block itself rather than by the host. Checking it from the ports requires a full encrypt session followed by a decrypt session over the produced ciphertext. The stimulus does exactly that with Triple-DES. It computes every expected block from a bench model of the core stub, and then reads the chaining register back after each session. A second hard corner is the partial session: status acknowledgement interleaved with a pending result, and a length write arriving mid-session. These are reached by stalling the drain step while registers are poked.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_W     = 64;
  localparam int KEY_WORDS = 6;

  localparam int OFS_KEY_TOP = 'h14;
  localparam int OFS_IV_LO   = 'h18;
  localparam int OFS_IV_HI   = 'h1C;
  localparam int OFS_CTRL    = 'h20;
  localparam int OFS_LEN     = 'h24;
  localparam int OFS_DAT_LO  = 'h28;
  localparam int OFS_DAT_HI  = 'h2C;
  localparam int OFS_REV     = 'h30;
  localparam int OFS_MASK    = 'h34;
  localparam int OFS_STAT    = 'h3C;
  localparam int OFS_IEN     = 'h40;

  localparam int CTL_CBC  = 4;
  localparam int CTL_TDES = 3;
  localparam int CTL_ENC  = 2;
  localparam int EV_IN    = 1;
  localparam int EV_OUT   = 2;
  localparam int MSK_DIN  = 5;
  localparam int MSK_DOUT = 6;
  localparam int MSK_GO   = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_CORE,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/blkc_key_bank.sv
module blkc_key_bank #(
  parameter int ADDR_W  = 8,
  parameter int N_WORDS = 6,
  parameter int TOP_OFS = 'h14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  output logic [N_WORDS*32-1:0]  key_o
);
  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    // pairs are stored high-half first, walking down from the top offset
    localparam int WORD_OFS = TOP_OFS - 4 * (i ^ 1);
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          word_q <= '0;
      else if (we_i && addr_i == WORD_OFS[ADDR_W-1:0])      word_q <= wdata_i;
    end
    assign key_o[32*i +: 32] = word_q;
  end
endmodule

// File: rtl/blkc_seq.sv
module blkc_seq
  import blkc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             din_we_i,
  input  logic             din_hi_i,
  input  logic [31:0]      din_i,
  input  logic             dout_take_i,
  input  logic             iv_we_i,
  input  logic             iv_hi_i,
  input  logic [31:0]      iv_i,
  input  logic             cbc_i,
  input  logic             enc_i,
  input  logic             done_i,
  input  logic [63:0]      result_i,
  output logic             in_ready_o,
  output logic             out_ready_o,
  output logic             busy_o,
  output logic [LEN_W-1:0] remain_o,
  output logic [63:0]      dout_o,
  output logic [63:0]      chain_o,
  output logic             start_o,
  output logic [63:0]      block_o,
  output logic             ev_in_o,
  output logic             ev_out_o
);
  localparam logic [LEN_W-1:0] BLK_BYTES = LEN_W'(BLK_W / 8);

  seq_state_e       state_q;
  logic [LEN_W-1:0] remain_q;
  logic [63:0]      din_q, dout_q, chain_q;
  logic             start_q;
  logic [LEN_W-1:0] remain_next;
  logic             launch, refill, finish;

  assign remain_next = remain_q - BLK_BYTES;
  assign launch  = (state_q == ST_IDLE) && go_i && (remain_q >= BLK_BYTES);
  assign finish  = (state_q == ST_DRAIN) && dout_take_i;
  assign refill  = finish && (remain_next >= BLK_BYTES);

  assign ev_in_o  = launch || refill;
  assign ev_out_o = (state_q == ST_CORE) && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      din_q    <= '0;
      dout_q   <= '0;
      chain_q  <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (len_we_i && state_q == ST_IDLE) remain_q <= len_i;
      if (din_we_i && state_q == ST_FILL) begin
        if (din_hi_i) din_q[63:32] <= din_i;
        else          din_q[31:0]  <= din_i;
      end
      if (iv_we_i) begin
        if (iv_hi_i) chain_q[63:32] <= iv_i;
        else         chain_q[31:0]  <= iv_i;
      end
      unique case (state_q)
        ST_IDLE:  if (launch) state_q <= ST_FILL;
        ST_FILL: begin
          if (din_we_i && din_hi_i) begin
            state_q <= ST_CORE;
            start_q <= 1'b1;
          end
        end
        ST_CORE: begin
          if (done_i) begin
            dout_q  <= result_i;
            state_q <= ST_DRAIN;
            if (cbc_i) chain_q <= enc_i ? result_i : din_q;
          end
        end
        ST_DRAIN: begin
          if (finish) begin
            remain_q <= remain_next;
            state_q  <= refill ? ST_FILL : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (state_q == ST_FILL);
  assign out_ready_o = (state_q == ST_DRAIN);
  assign busy_o      = (state_q != ST_IDLE);
  assign remain_o    = remain_q;
  assign dout_o      = dout_q;
  assign chain_o     = chain_q;
  assign start_o     = start_q;
  assign block_o     = din_q;
endmodule

// File: rtl/blkc_irq.sv
module blkc_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stat_we_i,
  input  logic       ien_we_i,
  input  logic       mask_we_i,
  input  logic [7:0] wdata_i,
  input  logic       ev_in_i,
  input  logic       ev_out_i,
  input  logic       in_ready_i,
  input  logic       out_ready_i,
  output logic [1:0] stat_o,
  output logic [1:0] ien_o,
  output logic [1:0] mask_o,
  output logic       go_o,
  output logic       irq_o,
  output logic       dma_in_req_o,
  output logic       dma_out_req_o
);
  import blkc_pkg::*;
  logic [1:0] stat_q, ien_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
      mask_q <= '0;
    end else begin
      if (ien_we_i)  ien_q  <= {wdata_i[EV_OUT], wdata_i[EV_IN]};
      if (mask_we_i) mask_q <= {wdata_i[MSK_DOUT], wdata_i[MSK_DIN]};
      // new events win over a same-cycle acknowledge
      stat_q[0] <= ev_in_i  | (stat_q[0] & ~(stat_we_i & ~wdata_i[EV_IN]));
      stat_q[1] <= ev_out_i | (stat_q[1] & ~(stat_we_i & ~wdata_i[EV_OUT]));
    end
  end

  assign go_o          = mask_we_i && wdata_i[MSK_GO];
  assign stat_o        = stat_q;
  assign ien_o         = ien_q;
  assign mask_o        = mask_q;
  assign irq_o         = |(stat_q & ien_q);
  assign dma_in_req_o  = in_ready_i  & mask_q[0];
  assign dma_out_req_o = out_ready_i & mask_q[1];
endmodule

// File: rtl/blkc_regfront.sv
module blkc_regfront
  import blkc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 16,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              dma_in_req_o,
  output logic              dma_out_req_o,
  output logic              core_start_o,
  output logic [63:0]       core_block_o,
  output logic [191:0]      core_key_o,
  output logic [63:0]       core_iv_o,
  output logic              core_cbc_o,
  output logic              core_tdes_o,
  output logic              core_enc_o,
  input  logic              core_done_i,
  input  logic [63:0]       core_result_i
);
  localparam logic [ADDR_W-1:0] A_IV_LO  = OFS_IV_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_IV_HI  = OFS_IV_HI[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTRL   = OFS_CTRL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_LEN    = OFS_LEN[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_DAT_LO = OFS_DAT_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_DAT_HI = OFS_DAT_HI[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_REV    = OFS_REV[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_MASK   = OFS_MASK[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_STAT   = OFS_STAT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_IEN    = OFS_IEN[ADDR_W-1:0];
  localparam logic [31:0] REV_WORD = {21'b0, REV_MAJOR[2:0], 2'b0, REV_MINOR[5:0]};

  logic [2:0]       mode_q;   // {cbc, tdes, enc}
  logic             in_ready, out_ready, busy, go;
  logic [LEN_W-1:0] remain;
  logic [63:0]      dout, chain;
  logic             ev_in, ev_out;
  logic [1:0]       stat, ien, mask;
  logic [31:0]      rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mode_q <= '0;
    else if (wr_en_i && addr_i == A_CTRL) mode_q <= wdata_i[CTL_CBC:CTL_ENC];
  end

  blkc_key_bank #(
    .ADDR_W (ADDR_W),
    .N_WORDS(KEY_WORDS),
    .TOP_OFS(OFS_KEY_TOP)
  ) u_keys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .key_o  (core_key_o)
  );

  blkc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .len_we_i   (wr_en_i && addr_i == A_LEN),
    .len_i      (wdata_i[LEN_W-1:0]),
    .din_we_i   (wr_en_i && (addr_i == A_DAT_LO || addr_i == A_DAT_HI)),
    .din_hi_i   (addr_i == A_DAT_HI),
    .din_i      (wdata_i),
    .dout_take_i(rd_en_i && addr_i == A_DAT_HI),
    .iv_we_i    (wr_en_i && (addr_i == A_IV_LO || addr_i == A_IV_HI)),
    .iv_hi_i    (addr_i == A_IV_HI),
    .iv_i       (wdata_i),
    .cbc_i      (mode_q[2]),
    .enc_i      (mode_q[0]),
    .done_i     (core_done_i),
    .result_i   (core_result_i),
    .in_ready_o (in_ready),
    .out_ready_o(out_ready),
    .busy_o     (busy),
    .remain_o   (remain),
    .dout_o     (dout),
    .chain_o    (chain),
    .start_o    (core_start_o),
    .block_o    (core_block_o),
    .ev_in_o    (ev_in),
    .ev_out_o   (ev_out)
  );

  blkc_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stat_we_i    (wr_en_i && addr_i == A_STAT),
    .ien_we_i     (wr_en_i && addr_i == A_IEN),
    .mask_we_i    (wr_en_i && addr_i == A_MASK),
    .wdata_i      (wdata_i[7:0]),
    .ev_in_i      (ev_in),
    .ev_out_i     (ev_out),
    .in_ready_i   (in_ready),
    .out_ready_i  (out_ready),
    .stat_o       (stat),
    .ien_o        (ien),
    .mask_o       (mask),
    .go_o         (go),
    .irq_o        (irq_o),
    .dma_in_req_o (dma_in_req_o),
    .dma_out_req_o(dma_out_req_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_IV_LO:  rd_mux = chain[31:0];
      A_IV_HI:  rd_mux = chain[63:32];
      A_CTRL:   rd_mux = {27'b0, mode_q, in_ready, out_ready};
      A_LEN:    rd_mux = 32'(remain);
      A_DAT_LO: rd_mux = dout[31:0];
      A_DAT_HI: rd_mux = dout[63:32];
      A_REV:    rd_mux = REV_WORD;
      A_MASK:   rd_mux = {25'b0, mask, 5'b0};
      A_STAT:   rd_mux = {29'b0, stat, 1'b0};
      A_IEN:    rd_mux = {29'b0, ien, 1'b0};
      default:  rd_mux = '0;
    endcase
  end

  assign rdata_o     = rd_en_i ? rd_mux : '0;
  assign core_iv_o   = chain;
  assign core_cbc_o  = mode_q[2];
  assign core_tdes_o = mode_q[1];
  assign core_enc_o  = mode_q[0];
endmodule

// File: rtl/blkc_regfront_chk.sv
module blkc_regfront_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready,
  input logic             out_ready,
  input logic             busy,
  input logic [LEN_W-1:0] remain,
  input logic             core_start_o,
  input logic             core_done_i,
  input logic [63:0]      core_block_o,
  input logic             dma_in_req_o,
  input logic             dma_out_req_o
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (core_start_o) pend_q <= 1'b1;
    else if (core_done_i)  pend_q <= 1'b0;
  end

  assert_ready_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready && out_ready));
  assert_start_leaves_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> (!in_ready && !out_ready));
  assert_block_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> $stable(core_block_o));
  assert_out_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_ready) |-> $past(core_done_i));
  assert_remain_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> (remain <= $past(remain)));
  assert_dma_in_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_in_req_o |-> in_ready);
  assert_dma_out_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_out_req_o |-> out_ready);
endmodule

bind blkc_regfront blkc_regfront_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_ready     (in_ready),
  .out_ready    (out_ready),
  .busy         (busy),
  .remain       (remain),
  .core_start_o (core_start_o),
  .core_done_i  (core_done_i),
  .core_block_o (core_block_o),
  .dma_in_req_o (dma_in_req_o),
  .dma_out_req_o(dma_out_req_o)
);

// File: tb/blkc_regfront_bench.sv
module blkc_regfront_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq, dma_in, dma_out;
  logic         c_start, c_cbc, c_tdes, c_enc;
  logic [63:0]  c_block, c_iv;
  logic [191:0] c_key;
  logic         c_done = 1'b0;
  logic [63:0]  c_result = '0;

  int n_chk = 0, n_bad = 0, n_starts = 0;
  int stub_cnt = 0;
  logic [63:0] stub_res = '0;

  always #4 clk = ~clk;

  blkc_regfront u_blkc_regfront (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .dma_in_req_o(dma_in), .dma_out_req_o(dma_out),
    .core_start_o(c_start), .core_block_o(c_block), .core_key_o(c_key),
    .core_iv_o(c_iv), .core_cbc_o(c_cbc), .core_tdes_o(c_tdes),
    .core_enc_o(c_enc), .core_done_i(c_done), .core_result_i(c_result)
  );

  function automatic logic [63:0] model(input logic [63:0] blk, input logic [63:0] iv,
      input logic [191:0] key, input logic cbc, input logic tdes, input logic enc);
    logic [63:0] km, x;
    km = tdes ? (key[63:0] ^ key[127:64] ^ key[191:128]) : key[63:0];
    if (enc) begin
      x = cbc ? (blk ^ iv) : blk;
      return {x[31:0], x[63:32]} ^ km;
    end
    x = blk ^ km;
    x = {x[31:0], x[63:32]};
    return cbc ? (x ^ iv) : x;
  endfunction

  // core stub: three-cycle latency
  always @(posedge clk) begin
    c_done <= 1'b0;
    if (stub_cnt > 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) begin
        c_done   <= 1'b1;
        c_result <= stub_res;
      end
    end else if (c_start) begin
      stub_res <= model(c_block, c_iv, c_key, c_cbc, c_tdes, c_enc);
      stub_cnt <= 3;
      n_starts <= n_starts + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_out(input string req);
    logic [31:0] v;
    for (int i = 0; i < 60; i++) begin
      rd(8'h20, v);
      if (v[0]) return;
    end
    chk(req, 64'd0, 64'd1);
  endtask

  task automatic run_block(input logic [63:0] din, output logic [63:0] dout);
    logic [31:0] lo, hi;
    wr(8'h28, din[31:0]);
    wr(8'h2C, din[63:32]);
    wait_out("R7 wait");
    rd(8'h28, lo);
    rd(8'h2C, hi);
    dout = {hi, lo};
  endtask

  logic [191:0] key_img;

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h20, v); chk("R1 ctrl", 64'(v), 64'd0);
    rd(8'h3C, v); chk("R1 status", 64'(v), 64'd0);
    rd(8'h24, v); chk("R1 length", 64'(v), 64'd0);
    chk("R1 pins", {60'd0, irq, dma_in, dma_out, c_start}, 64'd0);
    rd(8'h30, v); chk("R2 revision", 64'(v), 64'h0000_0205);
  endtask

  task automatic t_keys_ctrl;
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      key_img[32*i +: 32] = 32'hA5C3_0000 + 32'(i * 32'h1111);
      wr(8'(8'h14 - 4 * (i ^ 1)), key_img[32*i +: 32]);
    end
    for (int i = 0; i < 6; i++)
      chk($sformatf("R3 key word %0d", i), 64'(c_key[32*i +: 32]), 64'(key_img[32*i +: 32]));
    wr(8'h20, 32'h0000_001F);
    rd(8'h20, v); chk("R4 ctrl bits, ready flags read-only", 64'(v), 64'h1C);
    chk("R4 core mode pins", {61'd0, c_cbc, c_tdes, c_enc}, 64'd7);
  endtask

  task automatic t_idle_ignore;
    logic [31:0] v;
    int s0;
    s0 = n_starts;
    wr(8'h20, 32'h4);
    wr(8'h28, 32'h1234_5678);
    wr(8'h2C, 32'h9ABC_DEF0);
    repeat (6) @(negedge clk);
    chk("R6 idle data write starts nothing", 64'(n_starts), 64'(s0));
    wr(8'h24, 32'd4);
    wr(8'h34, 32'h80);
    rd(8'h20, v); chk("R5 short length stays idle", 64'(v[1:0]), 64'd0);
  endtask

  task automatic t_ecb;
    logic [31:0] v;
    logic [63:0] pa, pb, r;
    pa = 64'h0123_4567_89AB_CDEF;
    pb = 64'hFEDC_BA98_7654_3210;
    wr(8'h20, 32'h4);
    wr(8'h24, 32'd16);
    wr(8'h40, 32'h6);
    wr(8'h34, 32'h80);
    rd(8'h3C, v); chk("R5 status input event", 64'(v), 64'h2);
    rd(8'h20, v); chk("R5 input ready", 64'(v[1:0]), 64'h2);
    chk("R9 irq on input event", 64'(irq), 64'd1);
    wr(8'h28, pa[31:0]);
    wr(8'h2C, pa[63:32]);
    rd(8'h20, v); chk("R6 input ready drops after launch", 64'(v[1]), 64'd0);
    wait_out("R7 ecb wait");
    rd(8'h3C, v); chk("R7 status both events", 64'(v), 64'h6);
    wr(8'h3C, 32'h4);
    rd(8'h3C, v); chk("R9 ack input keeps output", 64'(v), 64'h4);
    wr(8'h3C, 32'h0);
    chk("R9 irq low after ack", 64'(irq), 64'd0);
    rd(8'h28, v); chk("R7 result low word", 64'(v), 64'(model(pa, 0, key_img, 0, 0, 1) & 64'hFFFF_FFFF));
    rd(8'h28, v); chk("R12 repeat low read no effect", 64'(v), 64'(model(pa, 0, key_img, 0, 0, 1) & 64'hFFFF_FFFF));
    rd(8'h2C, v); chk("R7 result high word", 64'(v), model(pa, 0, key_img, 0, 0, 1) >> 32);
    rd(8'h24, v); chk("R8 length after one block", 64'(v), 64'd8);
    rd(8'h20, v); chk("R8 input ready again", 64'(v[1:0]), 64'h2);
    run_block(pb, r);
    chk("R7 second ecb block", r, model(pb, 0, key_img, 0, 0, 1));
    rd(8'h24, v); chk("R8 length drained", 64'(v), 64'd0);
    rd(8'h20, v); chk("R8 idle after last block", 64'(v[1:0]), 64'd0);
    rd(8'h2C, v); chk("R12 data read when not ready", 64'(v), model(pb, 0, key_img, 0, 0, 1) >> 32);
    rd(8'h24, v); chk("R12 no side effect on length", 64'(v), 64'd0);
    wr(8'h3C, 32'h0);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_cbc;
    logic [31:0] v;
    logic [63:0] iv, p1, p2, c1, c2, e1, e2, r;
    iv = 64'h1122_3344_5566_7788;
    p1 = 64'hDEAD_BEEF_0BAD_F00D;
    p2 = 64'h0F1E_2D3C_4B5A_6978;
    e1 = model(p1, iv, key_img, 1, 1, 1);
    e2 = model(p2, e1, key_img, 1, 1, 1);
    wr(8'h20, 32'h1C);
    wr(8'h18, iv[31:0]);
    wr(8'h1C, iv[63:32]);
    wr(8'h24, 32'd16);
    wr(8'h34, 32'h80);
    run_block(p1, c1);
    chk("R11 cbc encrypt block 1", c1, e1);
    run_block(p2, c2);
    chk("R11 cbc encrypt block 2 chained", c2, e2);
    rd(8'h18, v); chk("R11 chain low after encrypt", 64'(v), e2 & 64'hFFFF_FFFF);
    rd(8'h1C, v); chk("R11 chain high after encrypt", 64'(v), e2 >> 32);
    wr(8'h20, 32'h18);
    wr(8'h18, iv[31:0]);
    wr(8'h1C, iv[63:32]);
    wr(8'h24, 32'd16);
    wr(8'h34, 32'h80);
    run_block(c1, r);
    chk("R11 cbc decrypt block 1", r, p1);
    run_block(c2, r);
    chk("R11 cbc decrypt block 2", r, p2);
    rd(8'h1C, v); chk("R11 chain holds last ciphertext", 64'(v), c2 >> 32);
    wr(8'h3C, 32'h0);
  endtask

  task automatic t_dma;
    logic [31:0] v;
    logic [63:0] p, r;
    p = 64'h5555_AAAA_3333_CCCC;
    wr(8'h20, 32'h4);
    wr(8'h24, 32'd8);
    wr(8'h34, 32'hE0);
    rd(8'h34, v); chk("R10 mask readback, go reads 0", 64'(v), 64'h60);
    chk("R10 input request", {62'd0, dma_in, dma_out}, 64'h2);
    wr(8'h24, 32'h40);
    rd(8'h24, v); chk("R13 length write during session ignored", 64'(v), 64'd8);
    wr(8'h28, p[31:0]);
    wr(8'h2C, p[63:32]);
    wait_out("R10 dma wait");
    chk("R10 output request", {62'd0, dma_in, dma_out}, 64'h1);
    rd(8'h28, v);
    rd(8'h2C, v);
    r = model(p, 0, key_img, 0, 0, 1);
    chk("R10 dma result high", 64'(v), r >> 32);
    chk("R10 requests low when idle", {62'd0, dma_in, dma_out}, 64'h0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    key_img = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_keys_ctrl();
    t_idle_ignore();
    t_ecb();
    t_cbc();
    t_dma();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule